// File: doc/BRIEF.md
# RTC Seconds and Subseconds Counter

This block keeps wall-clock time as a 32-bit count of whole seconds and a 15-bit count of subsecond ticks. A free-running 32.768 kHz tick enable, supplied from outside and asserted for one clock cycle per tick, advances the subsecond counter. When that counter rolls over from its top value, the seconds count steps up by one on the same edge. The subsecond field therefore counts exactly one second per wrap.

Software reaches the block through a simple single-cycle register bus. Each request is one cycle wide and the block always accepts it, so there is no back-pressure. A read request produces `rsp_valid` with its data on the following cycle, and that response cannot be stalled. The seconds value is not written directly. Software writes a separate load register, which sets the seconds value and zeroes the subsecond counter in one step. Software that needs a coherent seconds and subseconds pair must do the work itself: read seconds, read subseconds, read seconds again, and retry if the two seconds values differ.

Top module: `rtc_time_counter`

## Requirements
- R1: After reset, the seconds value and the subsecond value are both zero, and `rsp_valid` is low.
- R2: The subsecond counter increases by one on every clock edge where `tick_en` is high. It holds its value on every edge where `tick_en` is low.
- R3: A tick that arrives while the subsecond counter is 0x7FFF sets it to 0 and adds one to the seconds value on the same edge.
- R4: The seconds value wraps from 0xFFFFFFFF to 0 when a carry arrives from the subsecond counter.
- R5: A write to offset 0x0C loads the write data into the seconds value and clears the subsecond counter on the same edge. A tick in that cycle is dropped.
- R6: Writes to offset 0x00, offset 0x28 and any unmapped offset change neither the seconds value nor the subsecond value.
- R7: A read request returns its data with `rsp_valid` high on the next cycle. The data is the state from before the edge that captured the request. `rsp_valid` is low on every cycle that does not follow a read.
- R8: A read of offset 0x28 returns the subsecond counter in bits 14:0, with bits 31:15 as zero. A read of offset 0x00 returns the seconds value.
- R9: Reads of offset 0x0C and of every unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle 32.768 kHz tick enable |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_data | output | 32 | Read data |

## Verification
The bench runs the subsecond counter all the way to 0x7FFF and then over the wrap. A design that carried early, carried late, or lost the carry would return a seconds value that is off by one when read back. It issues a load in the same cycle as a tick. A design that let that tick through would leave the subsecond counter at 1 instead of 0. It writes to the read-only offsets and to an unmapped offset, then reads both counters back, which exposes any decode that leaks a write. It also reads while ticks are running, which catches a response that shows the state after the edge instead of before it.

// File: rtl/rtc_ss_pkg.sv
package rtc_ss_pkg;
  localparam int unsigned SEC_W  = 32;
  localparam int unsigned SUB_W  = 15;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_SECONDS = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_LOAD    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_SUBSEC  = 8'h28;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_SECONDS,
    SEL_SUBSEC
  } rd_sel_e;
endpackage

// File: rtl/rtc_subsec_ctr.sv
module rtc_subsec_ctr #(
  parameter int unsigned SUB_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  output logic [SUB_W-1:0] count,
  output logic             carry
);
  localparam logic [SUB_W-1:0] TOP = {SUB_W{1'b1}};

  // Carry only for a tick that is not overridden by a load.
  assign carry = tick && !clear && (count == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (clear)  count <= '0;
    else if (tick)   count <= count + 1'b1;
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear) |=> $stable(count));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear && count != TOP) |=> (count == $past(count) + 1'b1));
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear && count == TOP) |=> (count == '0));
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0));
endmodule

// File: rtl/rtc_sec_reg.sv
module rtc_sec_reg #(
  parameter int unsigned SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEC_W-1:0] load_val,
  input  logic             inc,
  output logic [SEC_W-1:0] seconds
);
  always_ff @(posedge clk) begin
    if (!rst_n)     seconds <= '0;
    else if (load)  seconds <= load_val;
    else if (inc)   seconds <= seconds + 1'b1;
  end

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (seconds == $past(load_val)));
  assert_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> (seconds == $past(seconds) + 1'b1));
  assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(seconds));
endmodule

// File: rtl/rtc_reg_if.sv
module rtc_reg_if
  import rtc_ss_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned SW  = SEC_W,
  parameter int unsigned SSW = SUB_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [SW-1:0] seconds,
  input  logic [SSW-1:0] subsec,
  output logic          load,
  output logic [SW-1:0] load_val,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  rd_sel_e       sel;
  logic          rd_req;
  logic [DW-1:0] rd_mux;

  assign load     = req_valid && req_write && (req_addr == OFF_LOAD);
  assign load_val = req_wdata[SW-1:0];
  assign rd_req   = req_valid && !req_write;

  always_comb begin
    unique case (req_addr)
      OFF_SECONDS: sel = SEL_SECONDS;
      OFF_SUBSEC:  sel = SEL_SUBSEC;
      default:     sel = SEL_NONE;
    endcase
  end

  always_comb begin
    case (sel)
      SEL_SECONDS: rd_mux = DW'(seconds);
      SEL_SUBSEC:  rd_mux = DW'(subsec);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_data <= rd_mux;
    end
  end

  assert_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);
  assert_norsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);
  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && req_addr == OFF_SUBSEC) |=> (rsp_data[DW-1:SSW] == '0));
  assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && req_addr != OFF_SECONDS && req_addr != OFF_SUBSEC) |=> (rsp_data == '0));
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_ss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic [SEC_W-1:0] seconds;
  logic [SUB_W-1:0] subsec;
  logic             load;
  logic [SEC_W-1:0] load_val;
  logic             carry;

  rtc_reg_if u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .seconds(seconds), .subsec(subsec),
    .load(load), .load_val(load_val),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  rtc_subsec_ctr #(.SUB_W(SUB_W)) u_sub (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .clear(load),
    .count(subsec), .carry(carry)
  );

  rtc_sec_reg #(.SEC_W(SEC_W)) u_sec (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .inc(carry), .seconds(seconds)
  );

  assert_carry_same_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(subsec[SUB_W-1]) && !$past(load)) |-> (seconds == $past(seconds) + 1'b1));
endmodule

// File: tb/test_rtc_time_counter.sv
module test_rtc_time_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int cyc    = 0;

  logic [31:0] m_sec = '0;
  logic [14:0] m_sub = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  rtc_time_counter i_rtc_time_counter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Driver: one bus cycle, expected read data pushed, reference model advanced.
  task automatic step(input logic tk, input logic v, input logic w,
                      input logic [7:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    tick_en = tk; req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    if (v && !w) begin
      if (a == 8'h00)      exp_q.push_back(m_sec);
      else if (a == 8'h28) exp_q.push_back({17'd0, m_sub});
      else                 exp_q.push_back(32'd0);
      tag_q.push_back(tag);
    end
    if (v && w && a == 8'h0C) begin
      m_sec = d; m_sub = '0;
    end else if (tk) begin
      if (m_sub == 15'h7FFF) begin m_sub = '0; m_sec = m_sec + 1; end
      else m_sub = m_sub + 1'b1;
    end
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(1'b0, 1'b1, 1'b0, a, 32'd0, tag);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 8'h00, 32'd0, "");
  endtask

  // Monitor: compares each response against the scoreboard queue.
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) check("R7 unexpected rsp_valid", 32'd1, 32'd0);
        else check(tag_q.pop_front(), rsp_data, exp_q.pop_front());
      end else if (exp_q.size() != 0) begin
        check("R7 missing response", 32'd0, 32'd1);
        void'(exp_q.pop_front()); void'(tag_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    rd(8'h00, "R1 seconds zero");
    rd(8'h28, "R1 subsec zero");
    rd(8'h0C, "R9 load offset reads zero");
    rd(8'h04, "R9 unmapped reads zero");
    // R2: ticks interleaved with idle cycles
    for (int i = 0; i < 5; i++) begin
      ticks(1);
      step(1'b0, 1'b0, 1'b0, 8'h00, 32'd0, "");
    end
    rd(8'h28, "R2 subsec after 5 ticks");
    // R7: read while ticking returns pre-edge state
    step(1'b1, 1'b1, 1'b0, 8'h28, 32'd0, "R7 read during tick");
    rd(8'h28, "R7 read after tick");
    // R5: load with a tick in the same cycle
    step(1'b1, 1'b1, 1'b1, 8'h0C, 32'h1234_5678, "");
    rd(8'h28, "R5 subsec cleared and tick dropped");
    rd(8'h00, "R5 seconds loaded");
    // R3: run to 0x7FFF then wrap
    ticks(32767);
    rd(8'h28, "R8 subsec at top, upper bits zero");
    rd(8'h00, "R3 seconds before wrap");
    ticks(1);
    rd(8'h28, "R3 subsec wrapped to zero");
    rd(8'h00, "R3 seconds incremented");
    // R6: writes to read-only and unmapped offsets
    step(1'b0, 1'b1, 1'b1, 8'h00, 32'hDEAD_BEEF, "");
    step(1'b0, 1'b1, 1'b1, 8'h28, 32'h0000_1111, "");
    step(1'b0, 1'b1, 1'b1, 8'h40, 32'hFFFF_FFFF, "");
    rd(8'h00, "R6 seconds unchanged");
    rd(8'h28, "R6 subsec unchanged");
    // R4: seconds rollover
    step(1'b0, 1'b1, 1'b1, 8'h0C, 32'hFFFF_FFFF, "");
    ticks(100);
    rd(8'h28, "R5 subsec after second load");
    ticks(32668);
    rd(8'h00, "R4 seconds wrapped to zero");
    rd(8'h28, "R4 subsec zero after wrap");
    repeat (3) step(1'b0, 1'b0, 1'b0, 8'h00, 32'd0, "");
    check("R7 queue drained", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule